// File: doc/BRIEF.md
# Packed Saturating SIMD Subtractor

This block is a 256-bit vector subtract stage. For every element it subtracts the element of the second operand vector from the element of the first. A result that leaves the element's range is clamped to the nearest end of that range; it never wraps. Three control inputs set how an operation is done:

- the element size: 8-bit bytes or 16-bit words;
- the arithmetic: signed or unsigned saturation;
- the width mode, which chooses how the upper 128 result bits are formed.

In the destructive 128-bit mode the first operand also stands for the destination, so the upper half of the result carries that operand's upper half through unchanged. In the non-destructive 128-bit mode the upper half is cleared. In the 256-bit mode all lanes are computed.

Operations enter on a valid/ready input stream and leave on a valid/ready output stream through a single output register. An accepted operation appears at the output on the next clock edge. When the output is held by `out_ready` low, the block deasserts `in_ready`. The output register keeps its contents until the consumer takes them. An operation whose transfer is refused is not lost, because the producer keeps it presented. A per-byte flag vector reports which elements were clamped.

Top module: `psub_sat_simd`

## Requirements
- R1: In signed byte mode (`elem_word`=0, `sat_signed`=1), each byte result is the difference when it lies in -128..127. A larger difference gives 0x7F and a smaller one gives 0x80.
- R2: In signed word mode (`elem_word`=1, `sat_signed`=1), each 16-bit result is the difference when it lies in -32768..32767. A larger difference gives 0x7FFF and a smaller one gives 0x8000.
- R3: In unsigned mode (`sat_signed`=0), for either element size, a negative difference gives all zeros and a non-negative difference passes through unchanged.
- R4: Each element is computed on its own as first minus second. In byte mode a borrow never crosses into the neighbouring byte. Bytes sit at bits 8i+7..8i and words at bits 16i+15..16i.
- R5: With `width_mode`=0 (destructive 128-bit), `out_data[255:128]` equals `src_a[255:128]` of the same operation, and `out_sat[31:16]` is zero.
- R6: With `width_mode`=1 (non-destructive 128-bit), `out_data[255:128]` and `out_sat[31:16]` are zero.
- R7: With `width_mode`=2 or 3 (256-bit), all 256 result bits come from the saturating subtraction.
- R8: An operation accepted at a clock edge (`in_valid` and `in_ready` both high) is on `out_data`/`out_sat` with `out_valid` high right after that edge. With no new operation accepted and the output taken, `out_valid` drops after the edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data`, `out_sat` and `out_valid` hold, and an offered input is not taken.
- R10: `out_sat[i]` is high when byte i belongs to an element that was clamped. In word mode both bytes of a clamped word are flagged.
- R11: After reset, `out_valid`, `out_data` and `out_sat` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_a | input | 256 | First operand (minuend, and destination in mode 0) |
| src_b | input | 256 | Second operand (subtrahend) |
| elem_word | input | 1 | 0: byte elements, 1: word elements |
| sat_signed | input | 1 | 1: signed saturation, 0: unsigned |
| width_mode | input | 2 | 0: keep upper, 1: zero upper, 2/3: full 256-bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Saturated differences |
| out_sat | output | 32 | Per-byte clamp flags |

## Verification
Every result is due one clock edge after the edge that accepts its operation. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, half a cycle after they settle. During a stall the bench reads the output once per held cycle and expects the first result to stay put. The operation offered during the stall must then appear exactly one edge after `out_ready` returns high.

// File: rtl/psub_pkg.sv
package psub_pkg;
  localparam logic [1:0] WM_KEEP_UPPER = 2'd0;
  localparam logic [1:0] WM_ZERO_UPPER = 2'd1;
  localparam logic [1:0] WM_FULL       = 2'd2;
  localparam logic [1:0] WM_FULL_ALT   = 2'd3;
endpackage

// File: rtl/psub_elem.sv
module psub_elem #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output logic [W-1:0] res,
  output logic         clamped
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ax, bx, diff;

  always_comb begin
    ax   = sgn ? {a[W-1], a} : {1'b0, a};
    bx   = sgn ? {b[W-1], b} : {1'b0, b};
    diff = ax - bx;
    if (sgn) begin
      clamped = diff[W] != diff[W-1];
      res     = clamped ? (diff[W] ? SMIN : SMAX) : diff[W-1:0];
    end else begin
      clamped = diff[W];
      res     = clamped ? '0 : diff[W-1:0];
    end
  end

  // R1 / R2: a signed clamp lands on one end of the range
  always_comb begin
    if (clamped && sgn) begin
      assert_signed_clamp_end_R1: assert (res == SMAX || res == SMIN);
    end
  end

  // R3: an unsigned clamp always yields zero
  always_comb begin
    if (clamped && !sgn) begin
      assert_unsigned_floor_R3: assert (res == '0);
    end
  end
endmodule

// File: rtl/psub_slice.sv
module psub_slice #(
  parameter int ELEM_W  = 8,
  parameter int SLICE_W = 2 * ELEM_W
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               word_mode,
  input  logic               sgn,
  output logic [SLICE_W-1:0] res,
  output logic [SLICE_W/ELEM_W-1:0] flags
);
  localparam int NARROW = SLICE_W / ELEM_W;

  logic [SLICE_W-1:0] narrow_res;
  logic [NARROW-1:0]  narrow_cl;
  logic [SLICE_W-1:0] wide_res;
  logic               wide_cl;

  for (genvar g = 0; g < NARROW; g++) begin : g_narrow
    psub_elem #(.W(ELEM_W)) u_elem (
      .a       (a[g*ELEM_W +: ELEM_W]),
      .b       (b[g*ELEM_W +: ELEM_W]),
      .sgn     (sgn),
      .res     (narrow_res[g*ELEM_W +: ELEM_W]),
      .clamped (narrow_cl[g])
    );
  end

  psub_elem #(.W(SLICE_W)) u_wide (
    .a       (a),
    .b       (b),
    .sgn     (sgn),
    .res     (wide_res),
    .clamped (wide_cl)
  );

  always_comb begin
    res   = word_mode ? wide_res : narrow_res;
    flags = word_mode ? {NARROW{wide_cl}} : narrow_cl;
  end
endmodule

// File: rtl/psub_merge.sv
module psub_merge
  import psub_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int NFLAG  = 32
) (
  input  logic [DATA_W-1:0]   raw,
  input  logic [NFLAG-1:0]    raw_flag,
  input  logic [DATA_W/2-1:0] keep_upper,
  input  logic [1:0]          wmode,
  output logic [DATA_W-1:0]   data,
  output logic [NFLAG-1:0]    flag
);
  localparam int HALF  = DATA_W / 2;
  localparam int HFLAG = NFLAG / 2;

  always_comb begin
    unique case (wmode)
      WM_KEEP_UPPER: begin
        data = {keep_upper, raw[HALF-1:0]};
        flag = {{HFLAG{1'b0}}, raw_flag[HFLAG-1:0]};
      end
      WM_ZERO_UPPER: begin
        data = {{HALF{1'b0}}, raw[HALF-1:0]};
        flag = {{HFLAG{1'b0}}, raw_flag[HFLAG-1:0]};
      end
      WM_FULL, WM_FULL_ALT: begin
        data = raw;
        flag = raw_flag;
      end
      default: begin
        data = raw;
        flag = raw_flag;
      end
    endcase
  end
endmodule

// File: rtl/psub_sat_simd.sv
module psub_sat_simd
  import psub_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int ELEM_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        src_a,
  input  logic [DATA_W-1:0]        src_b,
  input  logic                     elem_word,
  input  logic                     sat_signed,
  input  logic [1:0]               width_mode,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data,
  output logic [DATA_W/ELEM_W-1:0] out_sat
);
  localparam int SLICE_W = 2 * ELEM_W;
  localparam int NSLICE  = DATA_W / SLICE_W;
  localparam int NBYTE   = DATA_W / ELEM_W;
  localparam int HALF    = DATA_W / 2;
  localparam int HFLAG   = NBYTE / 2;

  logic [DATA_W-1:0] raw_res, merged;
  logic [NBYTE-1:0]  raw_flag, merged_flag;
  logic              accept;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    psub_slice #(.ELEM_W(ELEM_W), .SLICE_W(SLICE_W)) u_slice (
      .a         (src_a[s*SLICE_W +: SLICE_W]),
      .b         (src_b[s*SLICE_W +: SLICE_W]),
      .word_mode (elem_word),
      .sgn       (sat_signed),
      .res       (raw_res[s*SLICE_W +: SLICE_W]),
      .flags     (raw_flag[s*2 +: 2])
    );
  end

  psub_merge #(.DATA_W(DATA_W), .NFLAG(NBYTE)) u_merge (
    .raw        (raw_res),
    .raw_flag   (raw_flag),
    .keep_upper (src_a[DATA_W-1:HALF]),
    .wmode      (width_mode),
    .data       (merged),
    .flag       (merged_flag)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= merged;
        out_sat  <= merged_flag;
      end
    end
  end

  // R8: an accepted operation is presented on the next edge
  assert_result_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R8: a taken result with nothing behind it leaves the output empty
  assert_drain_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9: a stalled result holds
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sat)));

  // R5: destructive mode carries the first operand's upper half
  assert_keep_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && width_mode == WM_KEEP_UPPER) |=>
      (out_data[DATA_W-1:HALF] == $past(src_a[DATA_W-1:HALF]) && out_sat[NBYTE-1:HFLAG] == '0));

  // R6: non-destructive 128-bit mode clears the upper half
  assert_zero_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && width_mode == WM_ZERO_UPPER) |=>
      (out_data[DATA_W-1:HALF] == '0 && out_sat[NBYTE-1:HFLAG] == '0));

  // R10: word mode flags both bytes of a word together
  assert_word_flag_pairs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && elem_word) |=> (out_sat[0] == out_sat[1]));
endmodule

// File: tb/psub_sat_simd_bench.sv
`timescale 1ns/1ps
module psub_sat_simd_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] src_a = '0, src_b = '0;
  logic         elem_word = 1'b0, sat_signed = 1'b0;
  logic [1:0]   width_mode = 2'd2;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;
  logic [31:0]  out_sat;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  psub_sat_simd u_psub_sat_simd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .elem_word(elem_word), .sat_signed(sat_signed),
    .width_mode(width_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sat(out_sat)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      v[32*k +: 32] = seed ^ {seed[15:0], seed[31:16]};
    end
    return v;
  endfunction

  function automatic void model(input logic [255:0] a, input logic [255:0] b, input bit word,
                                input bit sgn, input logic [1:0] wm,
                                output logic [255:0] r, output logic [31:0] f);
    int n;
    n = word ? 16 : 32;
    r = '0;
    f = '0;
    for (int i = 0; i < n; i++) begin
      int av, bv, d, lo, hi, c;
      bit cl;
      if (word && sgn) begin
        av = int'($signed(a[16*i +: 16])); bv = int'($signed(b[16*i +: 16])); lo = -32768; hi = 32767;
      end else if (word) begin
        av = int'(a[16*i +: 16]); bv = int'(b[16*i +: 16]); lo = 0; hi = 65535;
      end else if (sgn) begin
        av = int'($signed(a[8*i +: 8])); bv = int'($signed(b[8*i +: 8])); lo = -128; hi = 127;
      end else begin
        av = int'(a[8*i +: 8]); bv = int'(b[8*i +: 8]); lo = 0; hi = 255;
      end
      d = av - bv;
      cl = 1'b0;
      c = d;
      if (d > hi) begin c = hi; cl = 1'b1; end
      if (d < lo) begin c = lo; cl = 1'b1; end
      if (word) begin
        r[16*i +: 16] = c[15:0];
        f[2*i] = cl;
        f[2*i+1] = cl;
      end else begin
        r[8*i +: 8] = c[7:0];
        f[i] = cl;
      end
    end
    if (wm == 2'd0) begin
      r[255:128] = a[255:128];
      f[31:16] = '0;
    end else if (wm == 2'd1) begin
      r[255:128] = '0;
      f[31:16] = '0;
    end
  endfunction

  task automatic run_op(input logic [255:0] a, input logic [255:0] b, input bit word, input bit sgn,
                        input logic [1:0] wm, input string req);
    logic [255:0] er;
    logic [31:0]  ef;
    model(a, b, word, sgn, wm, er, ef);
    src_a = a; src_b = b; elem_word = word; sat_signed = sgn; width_mode = wm;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " valid"}, {255'd0, out_valid}, 256'd1);
    chk(out_data === er, {req, " data"}, out_data, er);
    chk(out_sat === ef, {req, " R10 flags"}, {224'd0, out_sat}, {224'd0, ef});
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R11 out_valid", {255'd0, out_valid}, 256'd0);
    chk(out_data === '0, "R11 out_data", out_data, 256'd0);
    chk(out_sat === '0, "R11 out_sat", {224'd0, out_sat}, 256'd0);
    chk(in_ready === 1'b1, "R11 in_ready", {255'd0, in_ready}, 256'd1);
  endtask

  task automatic t_signed_byte();
    logic [255:0] a, b;
    for (int i = 0; i < 32; i++) begin
      case (i % 4)
        0: begin a[8*i +: 8] = 8'h7F; b[8*i +: 8] = 8'hFF; end
        1: begin a[8*i +: 8] = 8'h80; b[8*i +: 8] = 8'h01; end
        2: begin a[8*i +: 8] = 8'h10; b[8*i +: 8] = 8'h20; end
        default: begin a[8*i +: 8] = 8'h80; b[8*i +: 8] = 8'h80; end
      endcase
    end
    run_op(a, b, 1'b0, 1'b1, 2'd2, "R1 edges");
    run_op(rnd256(), rnd256(), 1'b0, 1'b1, 2'd2, "R1 random");
  endtask

  task automatic t_signed_word();
    logic [255:0] a, b;
    for (int i = 0; i < 16; i++) begin
      case (i % 4)
        0: begin a[16*i +: 16] = 16'h7FFF; b[16*i +: 16] = 16'hFFFF; end
        1: begin a[16*i +: 16] = 16'h8000; b[16*i +: 16] = 16'h0001; end
        2: begin a[16*i +: 16] = 16'h0100; b[16*i +: 16] = 16'h0200; end
        default: begin a[16*i +: 16] = 16'h7FFE; b[16*i +: 16] = 16'hFFFF; end
      endcase
    end
    run_op(a, b, 1'b1, 1'b1, 2'd2, "R2 edges");
    run_op(rnd256(), rnd256(), 1'b1, 1'b1, 2'd2, "R2 random");
  endtask

  task automatic t_unsigned();
    run_op({32{8'h05}}, {32{8'h06}}, 1'b0, 1'b0, 2'd2, "R3 byte below zero");
    run_op({32{8'hFF}}, {32{8'hFF}}, 1'b0, 1'b0, 2'd2, "R3 byte equal");
    run_op(rnd256(), rnd256(), 1'b0, 1'b0, 2'd2, "R3 byte random");
    run_op(rnd256(), rnd256(), 1'b1, 1'b0, 2'd2, "R3 word random");
  endtask

  task automatic t_lanes();
    run_op({16{16'h0100}}, {16{16'h0001}}, 1'b0, 1'b0, 2'd2, "R4 byte no borrow");
    run_op({16{16'h0100}}, {16{16'h0001}}, 1'b1, 1'b0, 2'd2, "R4 word borrow");
  endtask

  task automatic t_modes();
    run_op(rnd256(), rnd256(), 1'b0, 1'b1, 2'd0, "R5 keep upper");
    run_op(rnd256(), rnd256(), 1'b1, 1'b0, 2'd0, "R5 keep upper word");
    run_op(rnd256(), rnd256(), 1'b0, 1'b1, 2'd1, "R6 zero upper");
    run_op(rnd256(), rnd256(), 1'b1, 1'b1, 2'd2, "R7 full");
    run_op(rnd256(), rnd256(), 1'b0, 1'b0, 2'd3, "R7 full alt");
  endtask

  task automatic t_latency();
    src_a = {32{8'h03}}; src_b = {32{8'h01}}; elem_word = 1'b0; sat_signed = 1'b0; width_mode = 2'd2;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R8 valid after one edge", {255'd0, out_valid}, 256'd1);
    chk(out_data === {32{8'h02}}, "R8 data after one edge", out_data, {32{8'h02}});
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 valid drops", {255'd0, out_valid}, 256'd0);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    src_a = {32{8'h09}}; src_b = {32{8'h04}}; elem_word = 1'b0; sat_signed = 1'b1; width_mode = 2'd2;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    src_a = {32{8'h20}}; src_b = {32{8'h01}};
    for (int k = 0; k < 3; k++) begin
      chk(in_ready === 1'b0, "R9 in_ready low", {255'd0, in_ready}, 256'd0);
      chk(out_valid === 1'b1 && out_data === {32{8'h05}}, "R9 held data", out_data, {32{8'h05}});
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_data === {32{8'h1F}}, "R9 next after release", out_data, {32{8'h1F}});
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 drained", {255'd0, out_valid}, 256'd0);
  endtask

  task automatic t_stream();
    logic [255:0] a0, b0, a1, b1, e0, e1;
    logic [31:0]  f0, f1;
    a0 = rnd256(); b0 = rnd256(); a1 = rnd256(); b1 = rnd256();
    model(a0, b0, 1'b1, 1'b1, 2'd2, e0, f0);
    model(a1, b1, 1'b0, 1'b0, 2'd1, e1, f1);
    src_a = a0; src_b = b0; elem_word = 1'b1; sat_signed = 1'b1; width_mode = 2'd2;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_data === e0 && out_sat === f0, "R8 stream first", out_data, e0);
    src_a = a1; src_b = b1; elem_word = 1'b0; sat_signed = 1'b0; width_mode = 2'd1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_data === e1 && out_sat === f1, "R8 stream second", out_data, e1);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signed_byte();
    t_signed_word();
    t_unsigned();
    t_lanes();
    t_modes();
    t_latency();
    t_backpressure();
    t_stream();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule